// File: doc/BRIEF.md
# Serial Register and Memory Access Port

This block is the synchronous serial slave through which a host configures a multi-channel front-end chip and reaches its channel memories. Every transfer runs on the rising edge of a free-running clock. A framing input tells the slave whether the current bit on the data line is command or payload. The data line is bidirectional: the host drives it while it sends commands and write data, and the slave drives it only while it returns read data. The pin is split into `sdaIn`, `sdaOut` and `sdaOe` so that the pad cell can sit outside the block.

A command is a 12-bit header sent while the framing line is high. After it come one decode cycle and the payload, with the framing line low. Writes to configuration registers pass through a shift register and are copied into the parallel holding register only when the last bit of the word arrives. Register reads and memory reads return one 16-bit word. A memory transfer can also run as a block, which streams consecutive words with automatic address increment until the host raises the framing line again. Four of the holding registers serve as the write and read address counters for the fast and slow memory banks.

Top module: `ser_access_port`

## Requirements
- R1: Inputs are sampled on the rising clock edge, and every field is sent most significant bit first. The header is taken only while `frameCtl` is high and is 12 bits long: bit 11 is the read flag (1 = read), bit 10 is the block flag, bit 9 is the memory flag (1 = memory, 0 = register), and bits 8..0 are the target index.
- R2: During and after reset, every holding register reads zero, `sdaOe` is low, and neither `memWe` nor `memRe` is asserted.
- R3: A register write is the header, then one decode cycle, then 16 data bits. The holding register changes only on the edge that takes the 16th bit. A write to an index at or above `NUM_REGS` changes nothing.
- R4: If `frameCtl` rises during the decode or data part of a transfer, the transfer is dropped and any partial word is discarded. The bit sampled in that cycle becomes the first header bit of a new command.
- R5: A read leaves `sdaOe` low in the decode cycle and in one turnaround cycle. It then drives low for one fetch cycle, followed by the 16 data bits. N words therefore take 14 + 17·N cycles counted from the first header bit.
- R6: A register read returns the holding value. For registers the block flag is ignored: after one word the slave goes idle and releases the line.
- R7: A memory write asserts `memWe` for one cycle with the 16-bit word, `memSel` equal to the target index, and `memAddr` taken from the bank's write address. Bit 0 of the index selects the bank (0 = fast, 1 = slow). Holding registers 0 and 1 are the fast and slow write addresses, and 2 and 3 are the fast and slow read addresses. After each write the address increments, and it wraps to 0 after `MEM_DEPTH`-1.
- R8: A memory read asserts `memRe` in the fetch cycle with the bank's read address. `memRdata` is taken at the end of that cycle, and the read address then increments.
- R9: A block memory read keeps going word after word. When the read address passes the last location it returns to 0, and the memory index moves to the next memory, or back to memory 0 after the last one. Reading then continues from that memory bank's own read address.
- R10: A block memory write stores each further 16-bit word at the next write address until the framing line rises.
- R11: While `frameCtl` is high, `sdaOe` is low in that same cycle. A fetch cycle that sees `frameCtl` high issues no `memRe` and leaves the read address unchanged.
- R12: If `frameCtl` falls before 12 header bits have been taken, the command is dropped. The data bits that follow write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Active-low reset |
| frameCtl | input | 1 | High marks header bits, low marks payload |
| sdaIn | input | 1 | Data line as seen at the pad |
| sdaOut | output | 1 | Read data driven toward the pad |
| sdaOe | output | 1 | Pad output enable for the data line |
| memSel | output | $clog2(NUM_MEM) | Selected channel memory |
| memAddr | output | DATA_W | Word address in the selected memory |
| memWe | output | 1 | One-cycle memory write strobe |
| memWdata | output | DATA_W | Word to be written |
| memRe | output | 1 | One-cycle memory read strobe |
| memRdata | input | DATA_W | Word returned by the memory in the strobe cycle |
| cfgOut | output | NUM_REGS*DATA_W | All holding registers, register i at bits i*DATA_W upward |

## Verification
Two things can fall in the same cycle: the fetch of the next word in a block read, and the first header bit of a new command. The bench raises `frameCtl` exactly in the cycle where the fetch would occur. In that cycle it requires `memRe` and `sdaOe` to be low. It then completes the new command, which reads back the read-address register, and checks that the address advanced only for the word actually delivered. A second overlap occurs when the framing line rises midway through a register write. Here the bench judges by reading the register back and finding its old value.

// File: rtl/sap_pkg.sv
`timescale 1ns/1ps
package sap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_DECODE,
    ST_WBITS,
    ST_TURN,
    ST_FETCH,
    ST_RBITS
  } sapState_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic ctrlShift;
    logic latchCmd;
    logic dataShift;
    logic regCommit;
    logic memCommit;
    logic loadOut;
    logic outShift;
  } sapStrobe_t;

  // number of flag bits above the index in the header
  localparam int HDR_FLAGS = 3;

  // holding registers used as memory address counters
  localparam int REG_WADDR_FAST = 0;
  localparam int REG_WADDR_SLOW = 1;
  localparam int REG_RADDR_FAST = 2;
  localparam int REG_RADDR_SLOW = 3;

endpackage

// File: rtl/sap_ctrl.sv
`timescale 1ns/1ps
module sap_ctrl
  import sap_pkg::*;
#(
  parameter int CTRL_W = 12,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameCtl,
  input  logic       cmdRead,
  input  logic       cmdBlock,
  input  logic       cmdMem,
  output sapStrobe_t strobe,
  output logic       lineDrive,
  output logic       bitPhase
);

  localparam int MAX_W = (CTRL_W > DATA_W) ? CTRL_W : DATA_W;
  localparam int CNT_W = $clog2(MAX_W) + 1;

  sapState_e  st, stNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    strobe  = '0;
    stNext  = st;
    cntNext = cnt;
    unique case (st)
      ST_IDLE: begin
        if (frameCtl) begin
          strobe.ctrlShift = 1'b1;
          stNext  = ST_CTRL;
          cntNext = CNT_W'(1);
        end
      end
      ST_CTRL: begin
        if (!frameCtl) begin
          stNext = ST_IDLE;                 // short header: dropped
        end else begin
          strobe.ctrlShift = 1'b1;
          if (cnt == CNT_W'(CTRL_W - 1)) begin
            stNext  = ST_DECODE;
            cntNext = '0;
          end else begin
            cntNext = cnt + CNT_W'(1);
          end
        end
      end
      default: begin
        if (frameCtl) begin
          // new header overrides whatever payload was in flight
          strobe.ctrlShift = 1'b1;
          stNext  = ST_CTRL;
          cntNext = CNT_W'(1);
        end else begin
          unique case (st)
            ST_DECODE: begin
              strobe.latchCmd = 1'b1;
              stNext  = cmdRead ? ST_TURN : ST_WBITS;
              cntNext = '0;
            end
            ST_WBITS: begin
              strobe.dataShift = 1'b1;
              if (cnt == CNT_W'(DATA_W - 1)) begin
                strobe.memCommit = cmdMem;
                strobe.regCommit = !cmdMem;
                cntNext = '0;
                if (!(cmdMem && cmdBlock)) stNext = ST_IDLE;
              end else begin
                cntNext = cnt + CNT_W'(1);
              end
            end
            ST_TURN: stNext = ST_FETCH;
            ST_FETCH: begin
              strobe.loadOut = 1'b1;
              stNext  = ST_RBITS;
              cntNext = '0;
            end
            ST_RBITS: begin
              strobe.outShift = 1'b1;
              if (cnt == CNT_W'(DATA_W - 1)) begin
                cntNext = '0;
                stNext  = (cmdMem && cmdBlock) ? ST_FETCH : ST_IDLE;
              end else begin
                cntNext = cnt + CNT_W'(1);
              end
            end
            default: stNext = ST_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= stNext;
      cnt <= cntNext;
    end
  end

  assign lineDrive = ((st == ST_FETCH) || (st == ST_RBITS)) && !frameCtl;
  assign bitPhase  = (st == ST_RBITS);

endmodule

// File: rtl/sap_dpath.sv
`timescale 1ns/1ps
module sap_dpath
  import sap_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 9,
  parameter int NUM_REGS  = 8,
  parameter int NUM_MEM   = 32,
  parameter int MEM_DEPTH = 2048
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sdaIn,
  input  sapStrobe_t                 strobe,
  input  logic [DATA_W-1:0]          memRdata,
  output logic                       cmdRead,
  output logic                       cmdBlock,
  output logic                       cmdMem,
  output logic                       outMsb,
  output logic [$clog2(NUM_MEM)-1:0] memSel,
  output logic [DATA_W-1:0]          memAddr,
  output logic                       memWe,
  output logic [DATA_W-1:0]          memWdata,
  output logic                       memRe,
  output logic [NUM_REGS*DATA_W-1:0] cfgOut
);

  localparam int CTRL_W = IDX_W + HDR_FLAGS;
  localparam int SEL_W  = $clog2(NUM_MEM);

  logic [CTRL_W-1:0]          ctrlSr;
  logic [DATA_W-1:0]          dataSr, outSr, wordIn, regRead;
  logic [NUM_REGS*DATA_W-1:0] regFlat;
  logic [SEL_W-1:0]           curSel;
  logic [IDX_W-1:0]           cmdIdx;
  logic                       regHit, bank, rdWrap, wrWrap;
  logic [DATA_W-1:0]          wrPtr, rdPtr;
  int                         wrIdx, rdIdx;

  assign cmdRead  = ctrlSr[CTRL_W-1];
  assign cmdBlock = ctrlSr[CTRL_W-2];
  assign cmdMem   = ctrlSr[CTRL_W-3];
  assign cmdIdx   = ctrlSr[IDX_W-1:0];
  assign regHit   = cmdIdx < IDX_W'(NUM_REGS);

  assign wordIn = {dataSr[DATA_W-2:0], sdaIn};

  assign bank   = curSel[0];
  assign wrIdx  = REG_WADDR_FAST + int'(bank);
  assign rdIdx  = REG_RADDR_FAST + int'(bank);
  assign wrPtr  = regFlat[wrIdx*DATA_W +: DATA_W];
  assign rdPtr  = regFlat[rdIdx*DATA_W +: DATA_W];
  assign wrWrap = wrPtr >= DATA_W'(MEM_DEPTH - 1);
  assign rdWrap = rdPtr >= DATA_W'(MEM_DEPTH - 1);

  assign memWe    = strobe.memCommit;
  assign memRe    = strobe.loadOut && cmdMem;
  assign memSel   = curSel;
  assign memAddr  = memWe ? wrPtr : rdPtr;
  assign memWdata = wordIn;

  always_comb begin
    regRead = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (cmdIdx == IDX_W'(i)) regRead = regFlat[i*DATA_W +: DATA_W];
    end
  end

  // header and payload shifters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlSr <= '0;
      dataSr <= '0;
      outSr  <= '0;
    end else begin
      if (strobe.ctrlShift) ctrlSr <= {ctrlSr[CTRL_W-2:0], sdaIn};
      if (strobe.dataShift) dataSr <= wordIn;
      if (strobe.loadOut)
        outSr <= cmdMem ? memRdata : (regHit ? regRead : '0);
      else if (strobe.outShift)
        outSr <= {outSr[DATA_W-2:0], 1'b0};
    end
  end

  // memory index, advanced when a bank's read address wraps
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSel <= '0;
    end else if (strobe.latchCmd) begin
      curSel <= cmdIdx[SEL_W-1:0];
    end else if (memRe && rdWrap) begin
      curSel <= (curSel == SEL_W'(NUM_MEM - 1)) ? '0 : curSel + SEL_W'(1);
    end
  end

  // holding registers, including the address counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regFlat <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (strobe.regCommit && regHit && (cmdIdx == IDX_W'(i)))
          regFlat[i*DATA_W +: DATA_W] <= wordIn;
        else if (memWe && (i == wrIdx))
          regFlat[i*DATA_W +: DATA_W] <= wrWrap ? '0 : wrPtr + DATA_W'(1);
        else if (memRe && (i == rdIdx))
          regFlat[i*DATA_W +: DATA_W] <= rdWrap ? '0 : rdPtr + DATA_W'(1);
      end
    end
  end

  assign cfgOut = regFlat;
  assign outMsb = outSr[DATA_W-1];

endmodule

// File: rtl/ser_access_port.sv
`timescale 1ns/1ps
module ser_access_port
  import sap_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 9,
  parameter int NUM_REGS  = 8,
  parameter int NUM_MEM   = 32,
  parameter int MEM_DEPTH = 2048
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       frameCtl,
  input  logic                       sdaIn,
  output logic                       sdaOut,
  output logic                       sdaOe,
  output logic [$clog2(NUM_MEM)-1:0] memSel,
  output logic [DATA_W-1:0]          memAddr,
  output logic                       memWe,
  output logic [DATA_W-1:0]          memWdata,
  output logic                       memRe,
  input  logic [DATA_W-1:0]          memRdata,
  output logic [NUM_REGS*DATA_W-1:0] cfgOut
);

  localparam int CTRL_W = IDX_W + HDR_FLAGS;

  sapStrobe_t strobe;
  logic cmdRead, cmdBlock, cmdMem, outMsb, lineDrive, bitPhase;

  sap_ctrl #(.CTRL_W(CTRL_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .frameCtl(frameCtl),
    .cmdRead(cmdRead), .cmdBlock(cmdBlock), .cmdMem(cmdMem),
    .strobe(strobe), .lineDrive(lineDrive), .bitPhase(bitPhase)
  );

  sap_dpath #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS),
    .NUM_MEM(NUM_MEM), .MEM_DEPTH(MEM_DEPTH)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .strobe(strobe),
    .memRdata(memRdata), .cmdRead(cmdRead), .cmdBlock(cmdBlock),
    .cmdMem(cmdMem), .outMsb(outMsb), .memSel(memSel),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .memRe(memRe), .cfgOut(cfgOut)
  );

  assign sdaOe  = lineDrive;
  assign sdaOut = lineDrive && bitPhase && outMsb;

endmodule

// File: rtl/sap_checker.sv
`timescale 1ns/1ps
module sap_checker #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       frameCtl,
  input logic                       sdaOe,
  input logic                       memWe,
  input logic                       memRe,
  input logic [NUM_REGS*DATA_W-1:0] cfgOut
);

  // R11: a header bit on the line always wins over read data
  a_r11_release_on_frame: assert property (@(posedge clk) disable iff (!rstN)
    frameCtl |-> !sdaOe);

  // R11: no fetch is issued in a cycle that starts a new header
  a_r11_no_fetch_on_frame: assert property (@(posedge clk) disable iff (!rstN)
    frameCtl |-> !memRe);

  // R4: a write never completes in a cycle marked as header
  a_r4_no_write_on_frame: assert property (@(posedge clk) disable iff (!rstN)
    frameCtl |-> !memWe);

  // R7: one memory strobe at a time
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  // R5: the cycle after a fetch drives the first data bit
  a_r5_drive_after_fetch: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> (sdaOe || frameCtl));

  // R3: holding registers change only after a payload cycle
  a_r3_commit_in_payload: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgOut) |-> $past(!frameCtl));

endmodule

bind ser_access_port sap_checker #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) chk_i (
  .clk(clk), .rstN(rstN), .frameCtl(frameCtl), .sdaOe(sdaOe),
  .memWe(memWe), .memRe(memRe), .cfgOut(cfgOut)
);

// File: tb/ser_access_port_tb_top.sv
`timescale 1ns/1ps
module ser_access_port_tb_top;

  localparam int DW = 16;
  localparam int IW = 9;
  localparam int NREG = 8;
  localparam int NMEM = 4;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameCtl = 1'b0;
  logic sdaIn = 1'b0;
  logic sdaOut, sdaOe, memWe, memRe;
  logic [1:0] memSel;
  logic [DW-1:0] memAddr, memWdata, memRdata;
  logic [NREG*DW-1:0] cfgOut;

  logic [DW-1:0] memModel [NMEM][DEPTH];
  int checks = 0;
  int errors = 0;
  int wrCount = 0;
  logic [1:0] lastSel;
  logic [DW-1:0] lastAddr, lastData;
  logic [DW-1:0] rdBuf [8];
  logic smpOe, smpOut, smpRe;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ser_access_port #(.DATA_W(DW), .IDX_W(IW), .NUM_REGS(NREG),
                    .NUM_MEM(NMEM), .MEM_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .frameCtl(frameCtl), .sdaIn(sdaIn),
    .sdaOut(sdaOut), .sdaOe(sdaOe), .memSel(memSel), .memAddr(memAddr),
    .memWe(memWe), .memWdata(memWdata), .memRe(memRe),
    .memRdata(memRdata), .cfgOut(cfgOut)
  );

  // bench memory: read in the same cycle, written on the edge
  always_comb memRdata = memModel[memSel][memAddr[1:0]];
  always @(posedge clk) begin
    if (rstN && memWe) begin
      wrCount <= wrCount + 1;
      lastSel <= memSel;
      lastAddr <= memAddr;
      lastData <= memWdata;
      memModel[memSel][memAddr[1:0]] <= memWdata;
    end
  end

  // {index, value} pairs written then read back
  localparam logic [24:0] WR_VEC [6] = '{
    {9'd4, 16'hA5C3}, {9'd5, 16'h0001}, {9'd6, 16'h8000},
    {9'd7, 16'hFFFF}, {9'd1, 16'h0002}, {9'd7, 16'h3C5A}
  };

  function automatic logic [DW-1:0] cfgReg(input int i);
    return cfgOut[i*DW +: DW];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic f, input logic b);
    @(negedge clk);
    frameCtl = f;
    sdaIn = b;
    #1;
    smpOe = sdaOe;
    smpOut = sdaOut;
    smpRe = memRe;
  endtask

  task automatic sendCtrl(input bit rd, input bit blk, input bit mem, input int idx, input bit chkFirst);
    logic [11:0] w;
    w = {rd, blk, mem, 9'(idx)};
    for (int i = 11; i >= 0; i--) begin
      cyc(1'b1, w[i]);
      if (chkFirst && i == 11) begin
        chk(smpOe == 1'b0, "R11 line released in overlapping fetch", 32'(smpOe), 0);
        chk(smpRe == 1'b0, "R11 fetch suppressed by new header", 32'(smpRe), 0);
      end
    end
  endtask

  task automatic sendWord(input logic [DW-1:0] v);
    for (int i = DW - 1; i >= 0; i--) cyc(1'b0, v[i]);
  endtask

  task automatic writeReg(input int idx, input logic [DW-1:0] v);
    sendCtrl(0, 0, 0, idx, 0);
    cyc(1'b0, 1'b0);
    sendWord(v);
    cyc(1'b0, 1'b0);
  endtask

  task automatic readWords(input bit mem, input bit blk, input int idx, input int n, input bit chkFirst);
    sendCtrl(1, blk, mem, idx, chkFirst);
    cyc(1'b0, 1'b0);
    chk(smpOe == 1'b0, "R5 released in decode", 32'(smpOe), 0);
    cyc(1'b0, 1'b0);
    chk(smpOe == 1'b0, "R5 released in turnaround", 32'(smpOe), 0);
    for (int w = 0; w < n; w++) begin
      cyc(1'b0, 1'b0);
      chk(smpOe == 1'b1 && smpOut == 1'b0, "R5 fetch cycle drives low", {smpOe, smpOut}, 32'h2);
      chk(smpRe == mem, "R8 read strobe in fetch cycle", 32'(smpRe), 32'(mem));
      for (int b = DW - 1; b >= 0; b--) begin
        cyc(1'b0, 1'b0);
        rdBuf[w][b] = smpOut;
        if (smpOe !== 1'b1) chk(0, "R5 driven during data bits", 32'(smpOe), 1);
      end
    end
  endtask

  task automatic endBlock();
    cyc(1'b1, 1'b0);   // one header bit then frame drops: R12 drop
    cyc(1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] snap;
    int wc;
    for (int m = 0; m < NMEM; m++)
      for (int a = 0; a < DEPTH; a++)
        memModel[m][a] = {4'(m), 4'hA, 8'(a * 17 + 3)};

    // R2 reset state
    repeat (3) @(negedge clk);
    chk(cfgOut == '0, "R2 registers zero in reset", 32'(cfgOut[31:0]), 0);
    chk(!sdaOe && !memWe && !memRe, "R2 no drive or strobe in reset", {sdaOe, memWe, memRe}, 0);
    rstN = 1'b1;
    cyc(1'b0, 1'b0);
    chk(cfgOut == '0 && !sdaOe, "R2 state after reset release", 32'(sdaOe), 0);

    // R1 R3 R6 table: write then read back, MSB first
    for (int v = 0; v < 6; v++) begin
      writeReg(int'(WR_VEC[v][24:16]), WR_VEC[v][15:0]);
      chk(cfgReg(int'(WR_VEC[v][24:16])) == WR_VEC[v][15:0], "R3 holding register written",
          32'(cfgReg(int'(WR_VEC[v][24:16]))), 32'(WR_VEC[v][15:0]));
      readWords(0, 0, int'(WR_VEC[v][24:16]), 1, 0);
      chk(rdBuf[0] == WR_VEC[v][15:0], "R1 R6 serial readback MSB first",
          32'(rdBuf[0]), 32'(WR_VEC[v][15:0]));
    end

    // R3 copy only on the last bit's edge
    sendCtrl(0, 0, 0, 4, 0);
    cyc(1'b0, 1'b0);
    for (int i = DW - 1; i >= 0; i--) begin
      cyc(1'b0, 16'h1234 >> i);
      if (i == 0) chk(cfgReg(4) == 16'hA5C3, "R3 unchanged before last edge", 32'(cfgReg(4)), 32'hA5C3);
    end
    cyc(1'b0, 1'b0);
    chk(cfgReg(4) == 16'h1234, "R3 updated after last edge", 32'(cfgReg(4)), 32'h1234);

    // R3 index out of range
    snap = cfgReg(7);
    writeReg(9, 16'hDEAD);
    chk(cfgReg(7) == snap && cfgReg(1) == 16'h0002, "R3 out-of-range index ignored", 32'(cfgReg(7)), 32'(snap));

    // R4 abandon mid-word, next header starts in the same cycle
    sendCtrl(0, 0, 0, 5, 0);
    cyc(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1);
    readWords(0, 0, 5, 1, 0);
    chk(rdBuf[0] == 16'h0001, "R4 partial write discarded", 32'(rdBuf[0]), 1);

    // R12 short header
    wc = wrCount;
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0);
    for (int i = 0; i < 17; i++) cyc(1'b0, 1'b1);
    chk(cfgReg(6) == 16'h8000 && cfgReg(0) == 0 && wrCount == wc, "R12 short header dropped",
        32'(cfgReg(6)), 32'h8000);

    // R6 block flag on a register
    readWords(0, 1, 4, 1, 0);
    chk(rdBuf[0] == 16'h1234, "R6 block register read value", 32'(rdBuf[0]), 32'h1234);
    cyc(1'b0, 1'b0);
    chk(!smpOe && !smpRe, "R6 idle after one word", {smpOe, smpRe}, 0);

    // R7 single memory write, fast bank
    writeReg(0, 16'd1);
    wc = wrCount;
    sendCtrl(0, 0, 1, 2, 0);
    cyc(1'b0, 1'b0);
    sendWord(16'hBEEF);
    cyc(1'b0, 1'b0);
    chk(wrCount == wc + 1 && lastSel == 2'd2 && lastAddr == 16'd1 && lastData == 16'hBEEF,
        "R7 write strobe fields", {lastSel, lastAddr}, {2'd2, 16'd1});
    chk(cfgReg(0) == 16'd2, "R7 write address incremented", 32'(cfgReg(0)), 2);

    // R10 block write, slow bank, wrapping address
    writeReg(1, 16'd2);
    sendCtrl(0, 1, 1, 3, 0);
    cyc(1'b0, 1'b0);
    sendWord(16'h1111);
    sendWord(16'h2222);
    sendWord(16'h3333);
    endBlock();
    chk(memModel[3][2] == 16'h1111 && memModel[3][3] == 16'h2222 && memModel[3][0] == 16'h3333,
        "R10 block write words", 32'(memModel[3][0]), 32'h3333);
    chk(cfgReg(1) == 16'd1, "R10 write address wrapped", 32'(cfgReg(1)), 1);

    // R8 single memory read at last location
    writeReg(2, 16'd3);
    readWords(1, 0, 0, 1, 0);
    chk(rdBuf[0] == memModel[0][3], "R8 single read data", 32'(rdBuf[0]), 32'(memModel[0][3]));
    chk(cfgReg(2) == 16'd0, "R8 read address wrapped", 32'(cfgReg(2)), 0);

    // R9 block read crossing into the next memory
    writeReg(2, 16'd2);
    writeReg(3, 16'd1);
    readWords(1, 1, 0, 4, 0);
    endBlock();
    chk(rdBuf[0] == memModel[0][2] && rdBuf[1] == memModel[0][3], "R9 block words in first memory",
        32'(rdBuf[1]), 32'(memModel[0][3]));
    chk(rdBuf[2] == memModel[1][1] && rdBuf[3] == memModel[1][2], "R9 block continues in next memory",
        32'(rdBuf[2]), 32'(memModel[1][1]));
    chk(cfgReg(2) == 0 && cfgReg(3) == 16'd3, "R9 bank read addresses", {cfgReg(2), cfgReg(3)}, 32'h3);

    // R9 wrap from last memory to memory 0
    writeReg(3, 16'd3);
    readWords(1, 1, 3, 2, 0);
    endBlock();
    chk(rdBuf[0] == memModel[3][3] && rdBuf[1] == memModel[0][0], "R9 wrap past last memory",
        32'(rdBuf[1]), 32'(memModel[0][0]));

    // R11 header arrives in the fetch cycle of a block read
    writeReg(2, 16'd0);
    readWords(1, 1, 0, 1, 0);
    chk(rdBuf[0] == memModel[0][0], "R11 first block word", 32'(rdBuf[0]), 32'(memModel[0][0]));
    readWords(0, 0, 2, 1, 1);
    chk(rdBuf[0] == 16'd1, "R11 read address advanced once", 32'(rdBuf[0]), 1);

    cyc(1'b0, 1'b0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule